// File: doc/BRIEF.md
# Ethernet PHY Self-Test Traffic Engine

This block is a self-test engine that sits beside a PHY datapath. Its transmit side emits a programmed number of test packets onto a byte-wide transmit interface. Each packet carries a data-valid strobe and a fixed frame: a run of preamble bytes, a start delimiter, a fixed-length payload and an idle gap. The payload is either a 9-stage pseudo-random sequence or a single user byte repeated. A 3-bit decade code sets the packet count, and one code value selects continuous transmission.

The receive side watches a byte-wide receive interface without driving it. It counts every frame whose framing and payload match what the engine would itself send under the current settings. The count goes into a saturating counter twice the width of the readback window. Software reads that counter through the window, one half at a time. Reading the lower half freezes a copy of the whole count, so a following upper-half read belongs to the same value.

All configuration inputs are plain levels that a register file outside the block drives. Their reset value is 0, which leaves the engine idle in continuous, user-pattern mode.

Top module: `phy_bist_engine`

## Requirements
- R1: After reset, tx_valid and tx_done are 0, and rd_data reads 0 with either window half selected.
- R2: A 0-to-1 change of cfg_start while idle begins a run. Each packet holds tx_valid high for PRE_LEN bytes of 0x55, then one 0xD5 byte, then PAY_LEN payload bytes. It then holds tx_valid low for GAP_LEN cycles.
- R3: cfg_count_code sets the packet count: 3'b001 gives 1, 3'b010 gives 10, 3'b011 gives 100, 3'b100 gives 1,000, 3'b101 gives 10,000, 3'b110 gives 100,000 and 3'b111 gives 10,000,000. 3'b000 means continuous. Once the gap of the last counted packet ends, the engine goes idle and tx_done goes to 1. tx_done stays 1 until the next run starts.
- R4: With cfg_prbs_sel = 1, the payload follows x^9 + x^5 + 1. The 9-bit state is loaded with all ones at each delimiter. Each payload byte is the low 8 state bits, and the state then shifts 8 times (new bit = s[8]^s[4], shifted in at bit 0), so the first payload byte is 0xFF. With cfg_prbs_sel = 0, every payload byte equals cfg_user_byte.
- R5: Payload type, user byte and count code are captured when a run starts. Changing them during the run has no effect on tx_data.
- R6: Clearing cfg_start ends a run, in any mode, at the end of the current packet's gap, and tx_done stays 0. Holding cfg_start at 1 after a run ends does not start another run.
- R7: The receive counter rises by 1 in the cycle after rx_valid falls, but only if all of the following hold: the frame just ended was exactly PRE_LEN+1+PAY_LEN bytes; its framing bytes match R2; its payload matches R4 under the current cfg_prbs_sel and cfg_user_byte; and cfg_rx_en is 1. Any other frame leaves the counter unchanged.
- R8: The receive counter is cleared in the cycle after cfg_rx_en goes from 0 to 1. It stops at all ones.
- R9: With cfg_cnt_hi = 0, rd_data shows the live low half of the counter. A cycle with rd_en = 1 and cfg_cnt_hi = 0 copies the whole counter. With cfg_cnt_hi = 1, rd_data shows the upper half of that copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Run request; a rising level starts a run, a low level stops it |
| cfg_prbs_sel | input | 1 | Payload type: 1 pseudo-random, 0 user byte |
| cfg_user_byte | input | 8 | User payload byte |
| cfg_count_code | input | 3 | Decade packet-count code |
| cfg_rx_en | input | 1 | Receive counter enable |
| cfg_cnt_hi | input | 1 | Window half select: 0 low, 1 high |
| rd_en | input | 1 | Window read strobe |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| tx_done | output | 1 | Counted run finished |
| rd_data | output | WIN_W | Counter readback window |

## Verification
The bench builds the engine with PAY_LEN = 16, GAP_LEN = 4 and WIN_W = 4, and keeps PRE_LEN at its default of 7. Short frames let runs of ten packets and a stopped continuous run finish in a few hundred cycles. The 8-bit counter that WIN_W = 4 gives lets a few hundred injected frames drive it into saturation. It also lets the count cross from the low half into the high half, which shows the snapshot rule at work. Transmit traffic is looped back to the receiver in some phases. In the others the bench injects frames that are corrupted, short, long or carry a bad delimiter.

// File: rtl/phy_bist_pkg.sv
package phy_bist_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_PRE,
        TX_SFD,
        TX_PAY,
        TX_GAP
    } tx_state_e;

    localparam logic [7:0] PRE_BYTE  = 8'h55;
    localparam logic [7:0] SFD_BYTE  = 8'hD5;
    localparam logic [8:0] PRBS_SEED = 9'h1FF;
    localparam int         TGT_W     = 24;

    typedef struct packed {
        logic       prbs;
        logic [7:0] user;
        logic [2:0] code;
    } run_cfg_t;

    // eight shifts of x^9 + x^5 + 1, new bit enters at bit 0
    function automatic logic [8:0] prbs9_adv8(input logic [8:0] s);
        logic [8:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[7:0], t[8] ^ t[4]};
        end
        return t;
    endfunction

    function automatic logic [TGT_W-1:0] count_target(input logic [2:0] code);
        logic [TGT_W-1:0] n;
        unique case (code)
            3'd1:    n = TGT_W'(1);
            3'd2:    n = TGT_W'(10);
            3'd3:    n = TGT_W'(100);
            3'd4:    n = TGT_W'(1000);
            3'd5:    n = TGT_W'(10000);
            3'd6:    n = TGT_W'(100000);
            3'd7:    n = TGT_W'(10000000);
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bist_prbs9.sv
module bist_prbs9
    import phy_bist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       adv,
    output logic [7:0] byte_o
);
    logic [8:0] state;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state <= PRBS_SEED;
        end else if (adv) begin
            state <= prbs9_adv8(state);
        end
    end

    assign byte_o = state[7:0];
endmodule

// File: rtl/bist_tx_framer.sv
module bist_tx_framer
    import phy_bist_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAY_LEN = 64,
    parameter int GAP_LEN = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  run_cfg_t   cfg,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       done
);
    localparam int MAXL = (PRE_LEN > PAY_LEN) ? ((PRE_LEN > GAP_LEN) ? PRE_LEN : GAP_LEN)
                                              : ((PAY_LEN > GAP_LEN) ? PAY_LEN : GAP_LEN);
    localparam int IW = $clog2(MAXL + 1);
    localparam logic [IW-1:0] PRE_LAST = IW'(PRE_LEN - 1);
    localparam logic [IW-1:0] PAY_LAST = IW'(PAY_LEN - 1);
    localparam logic [IW-1:0] GAP_LAST = IW'(GAP_LEN - 1);

    tx_state_e        state;
    logic [IW-1:0]    idx;
    logic [TGT_W-1:0] sent;
    run_cfg_t         run;
    logic             start_q;
    logic             start_rise;
    logic [7:0]       prbs_byte;

    assign start_rise = start && !start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            idx     <= '0;
            sent    <= '0;
            done    <= 1'b0;
            run     <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start;
            unique case (state)
                TX_IDLE: if (start_rise) begin
                    state <= TX_PRE;
                    idx   <= '0;
                    sent  <= '0;
                    done  <= 1'b0;
                    run   <= cfg;
                end
                TX_PRE: begin
                    idx <= (idx == PRE_LAST) ? '0 : idx + 1'b1;
                    if (idx == PRE_LAST) state <= TX_SFD;
                end
                TX_SFD: begin
                    state <= TX_PAY;
                    idx   <= '0;
                end
                TX_PAY: begin
                    idx <= (idx == PAY_LAST) ? '0 : idx + 1'b1;
                    if (idx == PAY_LAST) begin
                        state <= TX_GAP;
                        sent  <= sent + 1'b1;
                    end
                end
                TX_GAP: begin
                    idx <= (idx == GAP_LAST) ? '0 : idx + 1'b1;
                    if (idx == GAP_LAST) begin
                        if (run.code != 3'd0 && sent == count_target(run.code)) begin
                            state <= TX_IDLE;
                            done  <= 1'b1;
                        end else if (!start) begin
                            state <= TX_IDLE;
                        end else begin
                            state <= TX_PRE;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    bist_prbs9 u_gen (
        .clk    (clk),
        .rst    (rst),
        .load   (state == TX_SFD),
        .adv    (state == TX_PAY),
        .byte_o (prbs_byte)
    );

    always_comb begin
        tx_valid = 1'b1;
        unique case (state)
            TX_PRE:  tx_data = PRE_BYTE;
            TX_SFD:  tx_data = SFD_BYTE;
            TX_PAY:  tx_data = run.prbs ? prbs_byte : run.user;
            default: begin
                tx_valid = 1'b0;
                tx_data  = 8'h00;
            end
        endcase
    end

    // R3
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state) == TX_GAP);
    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && start_q && start) |=> state == TX_IDLE);
    // R5
    run_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != TX_IDLE && $past(state) != TX_IDLE) |-> $stable(run));
endmodule

// File: rtl/bist_rx_counter.sv
module bist_rx_counter
    import phy_bist_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAY_LEN = 64,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             exp_prbs,
    input  logic [7:0]       exp_user,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic [CNT_W-1:0] count
);
    localparam int FRAME_LEN = PRE_LEN + 1 + PAY_LEN;
    localparam int IW = $clog2(FRAME_LEN + 1);
    localparam logic [IW-1:0] F_LEN = IW'(FRAME_LEN);
    localparam logic [IW-1:0] P_LEN = IW'(PRE_LEN);

    logic          v_q, good, en_q;
    logic [IW-1:0] idx, cur_idx;
    logic          cur_good, match, frame_end, clr;
    logic [7:0]    exp_byte, prbs_byte;

    assign cur_idx  = v_q ? idx  : '0;
    assign cur_good = v_q ? good : 1'b1;

    always_comb begin
        if (cur_idx < P_LEN)       exp_byte = PRE_BYTE;
        else if (cur_idx == P_LEN) exp_byte = SFD_BYTE;
        else                       exp_byte = exp_prbs ? prbs_byte : exp_user;
    end

    assign match     = (rx_data == exp_byte) && (cur_idx < F_LEN);
    assign frame_end = v_q && !rx_valid;
    assign clr       = rx_en && !en_q;

    bist_prbs9 u_ref (
        .clk    (clk),
        .rst    (rst),
        .load   (rx_valid && cur_idx == P_LEN),
        .adv    (rx_valid && cur_idx > P_LEN && cur_idx < F_LEN),
        .byte_o (prbs_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= 1'b0;
            good  <= 1'b0;
            idx   <= '0;
            en_q  <= 1'b0;
            count <= '0;
        end else begin
            v_q  <= rx_valid;
            en_q <= rx_en;
            if (rx_valid) begin
                idx  <= (cur_idx == F_LEN) ? cur_idx : cur_idx + 1'b1;
                good <= cur_good && match;
            end
            if (clr) begin
                count <= '0;
            end else if (frame_end && good && idx == F_LEN && rx_en && count != '1) begin
                count <= count + 1'b1;
            end
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '1 && !clr) |=> count == '1);
    // R8
    en_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !en_q) |=> count == '0);
    // R7
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !clr) |=> $stable(count));
endmodule

// File: rtl/phy_bist_engine.sv
module phy_bist_engine
    import phy_bist_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int PAY_LEN = 64,
    parameter int GAP_LEN = 12,
    parameter int WIN_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_start,
    input  logic             cfg_prbs_sel,
    input  logic [7:0]       cfg_user_byte,
    input  logic [2:0]       cfg_count_code,
    input  logic             cfg_rx_en,
    input  logic             cfg_cnt_hi,
    input  logic             rd_en,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_done,
    output logic [WIN_W-1:0] rd_data
);
    localparam int CNT_W = 2 * WIN_W;

    run_cfg_t         cfg;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] snap;

    assign cfg = '{prbs: cfg_prbs_sel, user: cfg_user_byte, code: cfg_count_code};

    bist_tx_framer #(
        .PRE_LEN (PRE_LEN),
        .PAY_LEN (PAY_LEN),
        .GAP_LEN (GAP_LEN)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (cfg_start),
        .cfg      (cfg),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .done     (tx_done)
    );

    bist_rx_counter #(
        .PRE_LEN (PRE_LEN),
        .PAY_LEN (PAY_LEN),
        .CNT_W   (CNT_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (cfg_rx_en),
        .exp_prbs (cfg_prbs_sel),
        .exp_user (cfg_user_byte),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .count    (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (rd_en && !cfg_cnt_hi) begin
            snap <= count;
        end
    end

    assign rd_data = cfg_cnt_hi ? snap[CNT_W-1:WIN_W] : count[WIN_W-1:0];

    // R9
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cfg_cnt_hi) |=> snap == $past(count));
    // R9
    snap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && !cfg_cnt_hi) |=> $stable(snap));
endmodule

// File: tb/phy_bist_engine_bench.sv
module phy_bist_engine_bench;
    localparam int PRE  = 7;
    localparam int PAY  = 16;
    localparam int GAP  = 4;
    localparam int WIN  = 4;
    localparam int CW   = 2 * WIN;
    localparam int FLEN = PRE + 1 + PAY;
    localparam int PER  = FLEN + GAP;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst = 1'b1;
    logic           start = 0, prbs = 0, rx_en = 0, cnt_hi = 0, rd_en = 0;
    logic [7:0]     user = 0;
    logic [2:0]     code = 0;
    logic           lb = 0, drv_v = 0;
    logic [7:0]     drv_d = 0;
    logic           tx_valid, tx_done;
    logic [7:0]     tx_data;
    logic [WIN-1:0] rd_data;
    logic           rxv;
    logic [7:0]     rxd;

    assign rxv = lb ? tx_valid : drv_v;
    assign rxd = lb ? tx_data  : drv_d;

    phy_bist_engine #(.PRE_LEN(PRE), .PAY_LEN(PAY), .GAP_LEN(GAP), .WIN_W(WIN)) u_phy_bist_engine (
        .clk(clk), .rst(rst), .cfg_start(start), .cfg_prbs_sel(prbs), .cfg_user_byte(user),
        .cfg_count_code(code), .cfg_rx_en(rx_en), .cfg_cnt_hi(cnt_hi), .rd_en(rd_en),
        .rx_valid(rxv), .rx_data(rxd), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_done(tx_done), .rd_data(rd_data)
    );

    int checks = 0, errors = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bprbs(input int k);
        logic [8:0] s = 9'h1FF;
        repeat (8 * k) s = {s[7:0], s[8] ^ s[4]};
        return s[7:0];
    endfunction

    function automatic int tgt(input logic [2:0] c);
        case (c)
            3'd1: return 1;        3'd2: return 10;
            3'd3: return 100;      3'd4: return 1000;
            3'd5: return 10000;    3'd6: return 100000;
            3'd7: return 10000000; default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(input int i, input logic p, input logic [7:0] u);
        if (i < PRE) return 8'h55;
        if (i == PRE) return 8'hD5;
        return p ? bprbs(i - PRE - 1) : u;
    endfunction

    // behavioural reference model
    bit         m_busy = 0, m_done = 0, m_sq = 0, m_prbs = 0, m_enq = 0, r_pv = 0, s_v = 0;
    int         m_pos = 0, m_sent = 0, m_cnt = 0, m_snap = 0;
    logic [7:0] m_user = 0, s_d = 0;
    logic [2:0] m_code = 0;
    logic [7:0] rq[$];

    function automatic bit frame_ok();
        if (rq.size() != FLEN) return 0;
        for (int i = 0; i < FLEN; i++)
            if (rq[i] != frame_byte(i, prbs, user)) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_sq = 0; m_pos = 0; m_sent = 0;
            m_cnt = 0; m_snap = 0; m_enq = 0; r_pv = 0; rq.delete();
        end else begin
            if (!m_busy) begin
                if (start && !m_sq) begin
                    m_busy = 1; m_pos = 0; m_sent = 0; m_done = 0;
                    m_prbs = prbs; m_user = user; m_code = code;
                end
            end else if (m_pos == PER - 1) begin
                m_pos = 0;
                if (m_code != 0 && m_sent == tgt(m_code)) begin m_busy = 0; m_done = 1; end
                else if (!start) m_busy = 0;
            end else begin
                if (m_pos == FLEN - 1) m_sent++;
                m_pos++;
            end
            m_sq = start;
            if (rd_en && !cnt_hi) m_snap = m_cnt;
            if (rx_en && !m_enq) m_cnt = 0;
            else if (r_pv && !s_v && rx_en && frame_ok() && m_cnt < CMAX) m_cnt++;
            m_enq = rx_en;
            if (s_v) begin
                if (!r_pv) rq.delete();
                rq.push_back(s_d);
            end
            r_pv = s_v;
        end
    end

    int  pkt_seen = 0, run_len = 0, gap_len = 0, last_burst = 0, last_gap = 0;
    logic [7:0] first_pay = 0;
    bit  prev_tv = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit ev;
            logic [7:0] ed;
            int er;
            ev = m_busy && m_pos < FLEN;
            ed = ev ? frame_byte(m_pos, m_prbs, m_user) : 8'h00;
            er = cnt_hi ? ((m_snap >> WIN) & ((1 << WIN) - 1)) : (m_cnt & ((1 << WIN) - 1));
            check(tx_valid == ev, "R2 tx_valid", tx_valid, ev);
            if (ev) check(tx_data == ed, "R4 tx_data", tx_data, ed);
            check(tx_done == m_done, "R3 tx_done", tx_done, m_done);
            check(rd_data == er, "R9 rd_data", rd_data, er);
            if (tx_valid && !prev_tv) begin
                pkt_seen++;
                if (prev_tv == 0 && gap_len > 0) last_gap = gap_len;
                run_len = 0;
            end
            if (tx_valid) begin
                if (run_len == PRE + 1) first_pay = tx_data;
                run_len++;
                gap_len = 0;
            end else begin
                if (prev_tv) last_burst = run_len;
                gap_len++;
            end
            prev_tv = tx_valid;
        end
        s_v = rxv;
        s_d = rxd;
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic send_frame(input int kind);
        logic [7:0] b[$];
        for (int i = 0; i < FLEN; i++) b.push_back(frame_byte(i, prbs, user));
        if (kind == 1) b[PRE + 3] = b[PRE + 3] ^ 8'h01;
        if (kind == 2) void'(b.pop_back());
        if (kind == 3) b.push_back(8'h00);
        if (kind == 4) b[PRE] = 8'hD4;
        foreach (b[i]) begin
            drv_v = 1; drv_d = b[i];
            step();
        end
        drv_v = 0; drv_d = 0;
        step(3);
    endtask

    initial begin
        int pc;
        step(5);
        rst = 0;
        @(negedge clk);
        check(tx_valid == 0 && tx_done == 0, "R1 idle outputs", {tx_valid, tx_done}, 0);
        check(rd_data == 0, "R1 window low", rd_data, 0);
        cnt_hi = 1;
        @(negedge clk);
        check(rd_data == 0, "R1 window high", rd_data, 0);
        cnt_hi = 0;

        // single user-pattern packet, config changed mid-run
        step();
        code = 3'd1; user = 8'hA5; prbs = 0; start = 1;
        step(PER / 2);
        user = 8'h3C; code = 3'd0; prbs = 1;     // R5: must not reach tx_data
        step(PER);
        @(negedge clk);
        check(tx_done == 1, "R3 done after one", tx_done, 1);
        check(pkt_seen == 1, "R3 one packet", pkt_seen, 1);
        check(last_burst == FLEN, "R2 burst length", last_burst, FLEN);
        step(40);
        @(negedge clk);
        check(pkt_seen == 1 && tx_valid == 0, "R6 no restart", pkt_seen, 1);
        start = 0;
        step();

        // ten PRBS packets in loopback
        rx_en = 1; lb = 1; prbs = 1; code = 3'd2;
        step();
        start = 1;
        step(10 * PER + 10);
        @(negedge clk);
        check(pkt_seen == 11, "R3 ten packets", pkt_seen, 11);
        check(tx_done == 1, "R3 done after ten", tx_done, 1);
        check(first_pay == 8'hFF, "R4 first prbs byte", first_pay, 8'hFF);
        check(last_gap == GAP, "R2 gap length", last_gap, GAP);
        check(rd_data == 10, "R7 loopback count", rd_data, 10);
        start = 0;
        step();

        // snapshot, then continuous run stopped by clearing start
        rd_en = 1;
        step();
        rd_en = 0; code = 3'd0; start = 1;
        step(8 * PER);
        start = 0;
        step(2 * PER);
        @(negedge clk);
        check(tx_done == 0, "R6 no done on stop", tx_done, 0);
        check(tx_valid == 0, "R6 stopped", tx_valid, 0);
        pc = pkt_seen - 11;
        check(rd_data == ((10 + pc) & 15), "R9 live low half", rd_data, (10 + pc) & 15);
        cnt_hi = 1;
        @(negedge clk);
        check(rd_data == 0, "R9 stale snapshot high", rd_data, 0);
        cnt_hi = 0; rd_en = 1;
        step();
        rd_en = 0; cnt_hi = 1;
        @(negedge clk);
        check(rd_data == (((10 + pc) >> 4) & 15), "R9 fresh snapshot high", rd_data, ((10 + pc) >> 4) & 15);
        cnt_hi = 0; lb = 0;

        // injected frames
        prbs = 0; user = 8'h5A; rx_en = 0;
        step();
        rx_en = 1;
        step();
        @(negedge clk);
        check(rd_data == 0, "R8 clear on enable", rd_data, 0);
        send_frame(0);
        @(negedge clk);
        check(rd_data == 1, "R7 good frame", rd_data, 1);
        for (int k = 1; k <= 4; k++) begin
            send_frame(k);
            @(negedge clk);
            check(rd_data == 1, $sformatf("R7 bad frame kind %0d", k), rd_data, 1);
        end
        rx_en = 0;
        step();
        send_frame(0);
        @(negedge clk);
        check(rd_data == 1, "R7 disabled no count", rd_data, 1);
        rx_en = 1;
        step();
        @(negedge clk);
        check(rd_data == 0, "R8 re-enable clears", rd_data, 0);
        prbs = 1;
        send_frame(0);
        @(negedge clk);
        check(rd_data == 1, "R4 prbs frame counted", rd_data, 1);

        // saturation
        prbs = 0;
        for (int k = 0; k < CMAX + 5; k++) send_frame(0);
        @(negedge clk);
        check(rd_data == 15, "R8 saturated low", rd_data, 15);
        rd_en = 1;
        step();
        rd_en = 0; cnt_hi = 1;
        @(negedge clk);
        check(rd_data == 15, "R8 saturated high", rd_data, 15);
        cnt_hi = 0;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule